// File: doc/BRIEF.md
# Dual INT8 Packed Multiply-Accumulator

This block computes two signed 8-bit dot products at once on one wide multiplier and one wide accumulator. Both streams use the same weight on every beat. One activation goes into the upper bits of a 27-bit packed operand and the other into the lower bits. The packed operand is multiplied by the sign-extended 18-bit weight. The single product then holds a·w in its high field and b·w in its low field, and it is added into a 48-bit accumulator. When a run ends, the two fields are pulled apart. The low field is read as a signed 18-bit value. The high field is corrected by adding back the borrow that a negative low field takes from it.

A run is controlled by a small state machine with three states: IDLE (no run open, input beats are ignored), RUN (products are accepted) and FULL (the product cap is reached, further beats are discarded). A clear strobe enters RUN from any state and zeroes the accumulator and the product count. On the same cycle, a valid beat is taken as the first product of the new run. A valid beat in RUN moves to FULL when it brings the count to the cap. A valid beat that also carries the final strobe returns the machine to IDLE from RUN or FULL and publishes both corrected sums one cycle later.

Top module: `dual_i8_mac`

## Requirements
- R1: On each accepted beat, act_a·weight is added to the high stream and act_b·weight to the low stream, as full signed two's-complement products. After the final beat, sum_a and sum_b equal the exact signed dot products, including when operands are −128.
- R2: A beat with in_clear and in_valid both high discards whatever was accumulated before and becomes the first product of a new run.
- R3: in_clear without in_valid zeroes the accumulator and the count, and opens a run. Later beats without in_clear then accumulate from zero.
- R4: out_valid is high for exactly the one cycle after an accepted-run beat that has in_valid and in_last both high. sum_a and sum_b change only on that cycle and hold their values otherwise.
- R5: When no run is open (after reset, or after a final beat), a beat with in_valid high and in_clear low is ignored. It neither accumulates nor raises out_valid, even with in_last high.
- R6: A run accepts at most 7 products. A valid beat that arrives after the seventh, with in_clear low, leaves the accumulator unchanged and sets limit_err. A final beat in this condition still publishes the sums of the first 7 products.
- R7: limit_err stays high until the next in_clear, and falls on the clock edge that samples in_clear.
- R8: While rst_n is low and directly after it rises, out_valid, limit_err, sum_a and sum_b are all 0 and no run is open.
- R9: A negative low-stream sum does not disturb the high-stream result, and a negative high-stream sum does not disturb the low-stream result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat strobe: act_a, act_b and weight are valid |
| in_clear | input | 1 | Start a new run; zero the accumulator and count |
| in_last | input | 1 | With in_valid, marks the final beat of the run |
| act_a | input | 8 | Signed activation for the high stream |
| act_b | input | 8 | Signed activation for the low stream |
| weight | input | 8 | Signed weight shared by both streams |
| sum_a | output | 18 | Signed dot product of act_a and weight |
| sum_b | output | 18 | Signed dot product of act_b and weight |
| out_valid | output | 1 | One-cycle pulse: sums are new |
| limit_err | output | 1 | Sticky: a beat beyond the product cap was dropped |

## Verification
The embedded properties check the following on every cycle:
- the product count never passes the cap;
- a beat in FULL leaves the accumulator untouched and raises limit_err;
- limit_err stays high until a clear;
- a clear alone zeroes the accumulator;
- IDLE ignores beats;
- out_valid is always caused by a final beat.

Only the bench scenarios can show that the separated sums are numerically right. This covers the borrow correction when the low field is negative, the −128 corners at the full 7-product run, the discarding of earlier runs by a clear, and the exact cycle on which the outputs change.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FULL = 2'd2
    } run_state_e;
endpackage

// File: rtl/dmac_pack.sv
module dmac_pack #(
    parameter int DW     = 8,
    parameter int LOW_W  = 18,
    parameter int OPA_W  = 27,
    parameter int OPC_W  = 18,
    parameter int PROD_W = OPA_W + OPC_W
) (
    input  logic signed [DW-1:0]     act_hi,
    input  logic signed [DW-1:0]     act_lo,
    input  logic signed [DW-1:0]     wgt,
    output logic signed [PROD_W-1:0] prod
);
    logic signed [OPA_W-1:0]  hi_ext;
    logic signed [OPA_W-1:0]  lo_ext;
    logic signed [OPA_W-1:0]  packed_op;
    logic signed [OPC_W-1:0]  w_ext;
    logic signed [PROD_W-1:0] mul_a;
    logic signed [PROD_W-1:0] mul_c;

    // Two activations share one operand; the low one sign-extends into the high field.
    assign hi_ext    = {{(OPA_W-DW){act_hi[DW-1]}}, act_hi};
    assign lo_ext    = {{(OPA_W-DW){act_lo[DW-1]}}, act_lo};
    assign packed_op = (hi_ext <<< LOW_W) + lo_ext;
    assign w_ext     = {{(OPC_W-DW){wgt[DW-1]}}, wgt};

    assign mul_a = {{OPC_W{packed_op[OPA_W-1]}}, packed_op};
    assign mul_c = {{OPA_W{w_ext[OPC_W-1]}}, w_ext};
    assign prod  = mul_a * mul_c;
endmodule

// File: rtl/dmac_acc.sv
module dmac_acc #(
    parameter int ACC_W  = 48,
    parameter int PROD_W = 45
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     add,
    input  logic signed [PROD_W-1:0] prod,
    output logic signed [ACC_W-1:0]  acc_q,
    output logic signed [ACC_W-1:0]  acc_d
);
    logic signed [ACC_W-1:0] base;
    logic signed [ACC_W-1:0] prod_ext;

    assign base     = clr ? '0 : acc_q;
    assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    assign acc_d    = add ? base + prod_ext : base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R3: a clear with no product leaves a zero accumulator
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !add) |=> (acc_q == '0));
endmodule

// File: rtl/dmac_split.sv
module dmac_split #(
    parameter int ACC_W = 48,
    parameter int LOW_W = 18
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [LOW_W-1:0] hi_sum,
    output logic signed [LOW_W-1:0] lo_sum
);
    localparam int HI_W = ACC_W - LOW_W;

    logic [HI_W-1:0] hi_raw;
    logic [HI_W-1:0] hi_fix;

    // A negative low field borrows one from the high field; its sign bit returns it.
    assign hi_raw = acc[ACC_W-1:LOW_W];
    assign hi_fix = hi_raw + {{(HI_W-1){1'b0}}, acc[LOW_W-1]};
    assign hi_sum = hi_fix[LOW_W-1:0];
    assign lo_sum = acc[LOW_W-1:0];
endmodule

// File: rtl/dual_i8_mac.sv
module dual_i8_mac #(
    parameter int DW    = 8,
    parameter int LOW_W = 18,
    parameter int OPA_W = 27,
    parameter int OPC_W = 18,
    parameter int ACC_W = 48,
    parameter int MAXP  = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_clear,
    input  logic                    in_last,
    input  logic signed [DW-1:0]    act_a,
    input  logic signed [DW-1:0]    act_b,
    input  logic signed [DW-1:0]    weight,
    output logic signed [LOW_W-1:0] sum_a,
    output logic signed [LOW_W-1:0] sum_b,
    output logic                    out_valid,
    output logic                    limit_err
);
    import dmac_pkg::*;

    localparam int PROD_W = OPA_W + OPC_W;
    localparam int CNT_W  = $clog2(MAXP + 1);
    localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MAXP);

    run_state_e st_q, st_d, st_eff;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_base;
    logic add, emit, err_set;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc_q, acc_d;
    logic signed [LOW_W-1:0]  hi_sum, lo_sum;

    dmac_pack #(.DW(DW), .LOW_W(LOW_W), .OPA_W(OPA_W), .OPC_W(OPC_W), .PROD_W(PROD_W)) u_pack (
        .act_hi(act_a), .act_lo(act_b), .wgt(weight), .prod(prod)
    );

    dmac_acc #(.ACC_W(ACC_W), .PROD_W(PROD_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(in_clear), .add(add),
        .prod(prod), .acc_q(acc_q), .acc_d(acc_d)
    );

    dmac_split #(.ACC_W(ACC_W), .LOW_W(LOW_W)) u_split (
        .acc(acc_d), .hi_sum(hi_sum), .lo_sum(lo_sum)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state and per-beat controls
    always_comb begin
        st_eff   = in_clear ? ST_RUN : st_q;
        cnt_base = in_clear ? '0 : cnt_q;
        st_d     = st_eff;
        cnt_d    = cnt_base;
        add      = 1'b0;
        emit     = 1'b0;
        err_set  = 1'b0;
        unique case (st_eff)
            ST_IDLE: begin
                st_d = ST_IDLE;
            end
            ST_RUN: begin
                if (in_valid) begin
                    add   = 1'b1;
                    cnt_d = cnt_base + 1'b1;
                    emit  = in_last;
                    if (in_last)                        st_d = ST_IDLE;
                    else if (cnt_base + 1'b1 == CNT_CAP) st_d = ST_FULL;
                    else                                 st_d = ST_RUN;
                end
            end
            ST_FULL: begin
                if (in_valid) begin
                    err_set = 1'b1;
                    emit    = in_last;
                    st_d    = in_last ? ST_IDLE : ST_FULL;
                end
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            limit_err <= 1'b0;
            sum_a     <= '0;
            sum_b     <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                sum_a <= hi_sum;
                sum_b <= lo_sum;
            end
            if (in_clear)     limit_err <= 1'b0;
            else if (err_set) limit_err <= 1'b1;
        end
    end

    // R6: the count never passes the cap
    a_r6_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_CAP);

    // R6: a beat beyond the cap leaves the accumulator alone and flags it
    a_r6_drop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FULL && in_valid && !in_clear) |=> ($stable(acc_q) && limit_err));

    // R7: the limit flag is sticky until a clear
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_err && !in_clear) |=> limit_err);

    // R5: beats outside a run are ignored
    a_r5_idle_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !in_clear) |=> ($stable(acc_q) && !out_valid));

    // R4: every result pulse follows a final beat
    a_r4_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_last));
endmodule

// File: tb/dual_i8_mac_test.sv
module dual_i8_mac_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_clear = 1'b0, in_last = 1'b0;
    logic signed [7:0] act_a = '0, act_b = '0, weight = '0;
    logic signed [17:0] sum_a, sum_b;
    logic out_valid, limit_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string cur_req = "R8";

    // Behavioural reference state
    bit m_open = 1'b0;
    int m_n = 0;
    int m_sa = 0, m_sb = 0;
    bit m_err = 1'b0;
    bit e_valid = 1'b0;
    int e_sa = 0, e_sb = 0;

    always #10 clk = ~clk;

    dual_i8_mac uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_clear(in_clear),
        .in_last(in_last), .act_a(act_a), .act_b(act_b), .weight(weight),
        .sum_a(sum_a), .sum_b(sum_b), .out_valid(out_valid), .limit_err(limit_err)
    );

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("out_valid", int'(out_valid), int'(e_valid));
        check("limit_err", int'(limit_err), int'(m_err));
        check("sum_a", int'(sum_a), e_sa);
        check("sum_b", int'(sum_b), e_sb);
    endtask

    task automatic model(input bit v, input bit c, input bit l,
                         input logic signed [7:0] a, input logic signed [7:0] b,
                         input logic signed [7:0] w);
        e_valid = 1'b0;
        if (c) begin
            m_open = 1'b1; m_n = 0; m_sa = 0; m_sb = 0; m_err = 1'b0;
        end
        if (v && m_open) begin
            if (m_n < 7) begin
                m_sa += int'(a) * int'(w);
                m_sb += int'(b) * int'(w);
                m_n++;
            end else begin
                m_err = 1'b1;
            end
            if (l) begin
                e_valid = 1'b1; e_sa = m_sa; e_sb = m_sb; m_open = 1'b0;
            end
        end
    endtask

    task automatic step(input bit v, input bit c, input bit l,
                        input logic signed [7:0] a, input logic signed [7:0] b,
                        input logic signed [7:0] w);
        @(negedge clk);
        in_valid = v; in_clear = c; in_last = l;
        act_a = a; act_b = b; weight = w;
        @(posedge clk);
        model(v, c, l, a, b, w);
        #5;
        compare_all();
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, 8'sd0, 8'sd0, 8'sd0);
    endtask

    function automatic logic signed [7:0] rnd8();
        if ($urandom_range(3) == 0) return -8'sd128;
        return 8'($urandom_range(255));
    endfunction

    initial begin
        // R8: reset state
        cur_req = "R8";
        repeat (3) begin
            @(posedge clk); #5; compare_all();
        end
        @(negedge clk); rst_n = 1'b1;
        idle();

        // R5: beats with no open run are ignored
        cur_req = "R5";
        step(1'b1, 1'b0, 1'b0, 8'sd5, 8'sd6, 8'sd7);
        step(1'b1, 1'b0, 1'b1, 8'sd9, 8'sd9, 8'sd9);
        idle();

        // R1: the -128 corner at the full cap
        cur_req = "R1";
        for (int i = 0; i < 7; i++)
            step(1'b1, i == 0, i == 6, -8'sd128, -8'sd128, -8'sd128);
        idle();
        for (int i = 0; i < 7; i++)
            step(1'b1, i == 0, i == 6, 8'sd127, -8'sd128, -8'sd128);
        idle();

        // R9: the low sum is negative, the high sum is positive, and the reverse
        cur_req = "R9";
        step(1'b1, 1'b1, 1'b0, 8'sd100, -8'sd90, 8'sd120);
        step(1'b1, 1'b0, 1'b1, 8'sd3, -8'sd1, 8'sd1);
        step(1'b1, 1'b1, 1'b1, -8'sd128, 8'sd127, 8'sd127);
        idle();

        // R5 again: after a final beat, beats without a clear are ignored
        cur_req = "R5";
        step(1'b1, 1'b0, 1'b1, 8'sd20, 8'sd20, 8'sd20);
        idle();

        // R2: a clear on the first beat discards earlier contents
        cur_req = "R2";
        step(1'b1, 1'b1, 1'b0, 8'sd50, 8'sd50, 8'sd50);
        step(1'b1, 1'b1, 1'b1, 8'sd2, -8'sd3, 8'sd4);
        idle();

        // R3: a clear alone opens the run; R4: gaps inside the run
        cur_req = "R3";
        step(1'b0, 1'b1, 1'b0, 8'sd0, 8'sd0, 8'sd0);
        idle();
        step(1'b1, 1'b0, 1'b0, -8'sd7, 8'sd11, -8'sd13);
        cur_req = "R4";
        idle();
        idle();
        step(1'b1, 1'b0, 1'b1, 8'sd1, 8'sd2, -8'sd128);
        idle();
        idle();

        // R6 and R7: an overlong run is capped, and the flag sticks until a clear
        cur_req = "R6";
        for (int i = 0; i < 10; i++)
            step(1'b1, i == 0, 1'b0, 8'sd120, -8'sd128, 8'sd127);
        step(1'b1, 1'b0, 1'b1, 8'sd99, 8'sd99, 8'sd99);
        cur_req = "R7";
        idle();
        idle();
        step(1'b0, 1'b1, 1'b0, 8'sd0, 8'sd0, 8'sd0);
        step(1'b1, 1'b0, 1'b1, 8'sd4, 8'sd4, 8'sd4);
        idle();

        // R1: random runs with gaps, covering overlong and stray beats
        cur_req = "R1";
        for (int r = 0; r < 400; r++) begin
            int len = $urandom_range(9, 1);
            for (int k = 0; k < len; k++) begin
                if ($urandom_range(4) == 0) idle();
                step(1'b1, k == 0, k == len - 1, rnd8(), rnd8(), rnd8());
            end
            if ($urandom_range(3) == 0) step(1'b1, 1'b0, 1'b1, rnd8(), rnd8(), rnd8());
            idle();
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL %s watchdog: got 0 expected 1", cur_req);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule